// File: doc/BRIEF.md
# Windowed and Time-out Watchdog Supervisor

This block supervises a host processor. The host keeps it satisfied by pulsing a trigger strobe, and it may reprogram it with a period code and an operating-style code. Time is counted only on cycles where a 1 ms enable tick is high, so the same logic runs at any clock rate and a bench can shrink time. The block counts ticks since the start of the current period. In windowed style, a trigger that arrives in the first half of the period is a fault. In time-out style, a trigger at any point is accepted. In both styles, running past the end of the period is a fault.

Period and style codes are checked for legality when they are written. An illegal code is treated as a fault, and the stored configuration is not changed. Any fault, and any external start-up indication, returns the supervisor to a start-up phase. In that phase the first trigger must arrive within a fixed start-up timeout. Each fault produces a one-cycle reset request. It also sets a sticky flag, which the host clears by a status read.

Top module: `wdog_supervisor`

## Requirements
- R1: After rst_ni is released, rst_req_o and fault_flag_o are low, and the supervisor is in the start-up phase with the period code 0 and style code 1 in force.
- R2: In windowed style, a trigger is accepted without a fault when at least P/2 ticks and fewer than P ticks have elapsed since the period began. Acceptance starts a new period.
- R3: In windowed style, a trigger after fewer than P/2 ticks of the running period causes a fault.
- R4: Without a trigger, the P-th tick of a running period causes a fault.
- R5: In time-out style, a trigger at any elapsed count, including zero, is accepted and starts a new period.
- R6: Period codes 0 to 9 are legal. P = BASE_MS × 2^code × scale. A write with a period code of 10 to 15 causes a fault and leaves both stored codes unchanged.
- R7: Style codes 0 to 5 are legal. Bit 0 set selects windowed style. Bits 2:1 select the scale: 0 gives ×1, 1 gives ×8, 2 gives ×16. A write with style code 6 or 7 causes a fault and leaves both stored codes unchanged.
- R8: The start-up phase begins on rst_ni, on a fault, or when startup_i is pulsed. In this phase any trigger is accepted and starts a running period. Reaching the STARTUP_MS-th tick without a trigger causes a fault.
- R9: A fault raises rst_req_o for exactly the one cycle after the faulting edge, and restarts the start-up count from zero.
- R10: fault_flag_o is set by every fault and cleared by stat_rd_i. If both happen in the same cycle, the set wins.
- R11: A legal configuration write during a running period applies at once and restarts the period count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 ms time-base enable |
| trig_i | input | 1 | Host trigger strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| period_code_i | input | 4 | Period code carried by the write |
| mode_code_i | input | 3 | Style code carried by the write |
| startup_i | input | 1 | Re-enter the start-up phase without a fault |
| stat_rd_i | input | 1 | Status read; clears the fault flag |
| rst_req_o | output | 1 | One-cycle system reset request |
| fault_flag_o | output | 1 | Sticky watchdog-fault flag |

## Verification
Triggers are placed one tick before the window opens, exactly at the opening, and one tick before expiry. This separates the early-fault path from the accepted path and from the expiry path. The same tick runs are repeated under time-out style and under the ×8 and ×16 scales, which shows that the style bit and the scale field are decoded. After each rejected write, the fault point is measured again to show that the old period survived. A legal write made mid-period is followed by a trigger that is legal only if the count restarted. A start-up pulse is followed by more idle ticks than one period holds, which shows that start-up timing has taken over from the period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PCODE_W = 4;
  localparam int MCODE_W = 3;

  typedef struct packed {
    logic       legal;
    logic       windowed;
    logic [2:0] shift;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MCODE_W-1:0] code);
    mode_dec_t d;
    d.legal    = (code < 3'd6);
    d.windowed = code[0];
    case (code[2:1])
      2'd1:    d.shift = 3'd3;
      2'd2:    d.shift = 3'd4;
      default: d.shift = 3'd0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int BASE_MS   = 20,
  parameter int N_PERIODS = 10,
  parameter int CNT_W     = 18,
  parameter int RST_PCODE = 0,
  parameter int RST_MCODE = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PCODE_W-1:0] period_code_i,
  input  logic [MCODE_W-1:0] mode_code_i,
  output logic               cfg_fault_o,
  output logic               cfg_upd_o,
  output logic               windowed_o,
  output logic [CNT_W-1:0]   period_o
);
  localparam int N_CODES = 1 << PCODE_W;

  logic [N_CODES-1:0] legal_mask;
  logic [PCODE_W-1:0] pcode_q;
  logic [MCODE_W-1:0] mcode_q;
  mode_dec_t          wr_dec, cur_dec;
  logic               wr_ok;

  for (genvar gi = 0; gi < N_CODES; gi++) begin : g_mask
    assign legal_mask[gi] = (gi < N_PERIODS);
  end

  always_comb begin
    wr_dec      = decode_mode(mode_code_i);
    cur_dec     = decode_mode(mcode_q);
    wr_ok       = legal_mask[period_code_i] & wr_dec.legal;
    cfg_fault_o = we_i & ~wr_ok;
    cfg_upd_o   = we_i & wr_ok;
    windowed_o  = cur_dec.windowed;
    period_o    = (CNT_W'(BASE_MS) << pcode_q) << cur_dec.shift;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcode_q <= PCODE_W'(RST_PCODE);
      mcode_q <= MCODE_W'(RST_MCODE);
    end else if (cfg_upd_o) begin
      pcode_q <= period_code_i;
      mcode_q <= mode_code_i;
    end
  end

  // R6/R7: rejected write leaves stored codes untouched
  p_keep_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_fault_o |=> ($stable(pcode_q) && $stable(mcode_q)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W      = 18,
  parameter int STARTUP_MS = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             startup_i,
  input  logic             cfg_upd_i,
  input  logic             cfg_fault_i,
  input  logic             windowed_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             fault_o
);
  localparam logic [CNT_W-1:0] STARTUP_W = CNT_W'(STARTUP_MS);

  logic             run_q;
  logic [CNT_W-1:0] elapsed_q, elapsed_inc, limit;
  logic             early, trig_fault, exp_fault;

  always_comb begin
    elapsed_inc = elapsed_q + 1'b1;
    limit       = run_q ? period_i : STARTUP_W;
    early       = run_q & windowed_i & (elapsed_q < (period_i >> 1));
    trig_fault  = trig_i & early;
    exp_fault   = tick_i & ~trig_i & (elapsed_inc >= limit);
    fault_o     = cfg_fault_i | trig_fault | exp_fault;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      elapsed_q <= '0;
    end else if (fault_o || startup_i) begin
      run_q     <= 1'b0;
      elapsed_q <= '0;
    end else if (trig_i) begin
      run_q     <= 1'b1;
      elapsed_q <= '0;
    end else if (cfg_upd_i && run_q) begin
      elapsed_q <= '0;
    end else if (tick_i) begin
      elapsed_q <= elapsed_inc;
    end
  end

  p_run_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (elapsed_q < period_i));
  p_start_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (elapsed_q < STARTUP_W));
  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (!run_q && elapsed_q == '0));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int BASE_MS    = 20,
  parameter int N_PERIODS  = 10,
  parameter int STARTUP_MS = 256,
  parameter int RST_PCODE  = 0,
  parameter int RST_MCODE  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               trig_i,
  input  logic               cfg_we_i,
  input  logic [PCODE_W-1:0] period_code_i,
  input  logic [MCODE_W-1:0] mode_code_i,
  input  logic               startup_i,
  input  logic               stat_rd_i,
  output logic               rst_req_o,
  output logic               fault_flag_o
);
  localparam int MAX_P = BASE_MS * (1 << (N_PERIODS - 1)) * 16;
  localparam int LIM   = (MAX_P > STARTUP_MS) ? MAX_P : STARTUP_MS;
  localparam int CNT_W = $clog2(LIM + 1);

  logic             cfg_fault, cfg_upd, windowed, fault;
  logic [CNT_W-1:0] period;

  wdog_cfg #(
    .BASE_MS(BASE_MS), .N_PERIODS(N_PERIODS), .CNT_W(CNT_W),
    .RST_PCODE(RST_PCODE), .RST_MCODE(RST_MCODE)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .period_code_i, .mode_code_i,
    .cfg_fault_o(cfg_fault), .cfg_upd_o(cfg_upd),
    .windowed_o(windowed), .period_o(period)
  );

  wdog_timer #(.CNT_W(CNT_W), .STARTUP_MS(STARTUP_MS)) u_timer (
    .clk_i, .rst_ni, .tick_i, .trig_i, .startup_i,
    .cfg_upd_i(cfg_upd), .cfg_fault_i(cfg_fault),
    .windowed_i(windowed), .period_i(period), .fault_o(fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o    <= 1'b0;
      fault_flag_o <= 1'b0;
    end else begin
      rst_req_o <= fault;
      if (fault)          fault_flag_o <= 1'b1;
      else if (stat_rd_i) fault_flag_o <= 1'b0;
    end
  end

  p_flag_on_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> fault_flag_o);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !fault) |=> !fault_flag_o);
  p_req_track_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault |=> !rst_req_o);
endmodule

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       tick_i = 0, trig_i = 0, cfg_we_i = 0, startup_i = 0, stat_rd_i = 0;
  logic [3:0] period_code_i = '0;
  logic [2:0] mode_code_i = '0;
  logic       rst_req_o, fault_flag_o;

  typedef struct {
    bit    rst;
    bit    flag;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0, n_fail = 0, cycles = 0;
  bit   exp_flag = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_supervisor #(.BASE_MS(4), .N_PERIODS(10), .STARTUP_MS(16)) u0 (
    .clk_i(clk), .rst_ni, .tick_i, .trig_i, .cfg_we_i, .period_code_i,
    .mode_code_i, .startup_i, .stat_rd_i, .rst_req_o, .fault_flag_o
  );

  // monitor
  always @(posedge clk) begin
    #1;
    cycles++;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      n_checks++;
      if (rst_req_o !== it.rst || fault_flag_o !== it.flag) begin
        n_fail++;
        $display("FAIL %s: rst_req=%0b flag=%0b, expected rst_req=%0b flag=%0b",
                 it.req, rst_req_o, fault_flag_o, it.rst, it.flag);
      end
    end
  end

  task automatic step(input bit tk, tg, we, input logic [3:0] pc,
                      input logic [2:0] mc, input bit su, rd, er, input string req);
    exp_t it;
    @(negedge clk);
    tick_i = tk; trig_i = tg; cfg_we_i = we; period_code_i = pc;
    mode_code_i = mc; startup_i = su; stat_rd_i = rd;
    if (er) exp_flag = 1;
    else if (rd) exp_flag = 0;
    it.rst = er; it.flag = exp_flag; it.req = req;
    q.push_back(it);
  endtask

  task automatic ticks(input int n, input bit last_rst, input string req);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, last_rst && (i == n-1), req);
  endtask
  task automatic trig(input bit er, input string req);
    step(0, 1, 0, 0, 0, 0, 0, er, req);
  endtask
  task automatic wr(input logic [3:0] pc, input logic [2:0] mc, input bit er, input string req);
    step(0, 0, 1, pc, mc, 0, 0, er, req);
  endtask

  initial begin
    #(3*CLK_PERIOD) rst_ni = 1'b1;
    step(0,0,0,0,0,0,0,0,"R1"); step(0,0,0,0,0,0,0,0,"R1");
    // start-up, then windowed P=4
    ticks(5, 0, "R8"); trig(0, "R8");
    ticks(2, 0, "R2"); trig(0, "R2");
    ticks(3, 0, "R2"); trig(0, "R2");
    ticks(1, 0, "R3"); trig(1, "R3");
    step(0,0,0,0,0,0,1,0,"R10");           // R9: pulse gone; R10: cleared
    ticks(16, 1, "R8");                    // start-up timeout
    step(0,0,0,0,0,0,1,0,"R10");
    trig(0, "R8"); ticks(3, 0, "R4"); ticks(1, 1, "R4");
    // time-out style, P=8
    wr(4'd1, 3'd0, 0, "R6"); trig(0, "R8"); trig(0, "R5");
    ticks(7, 0, "R5"); trig(0, "R5"); ticks(7, 0, "R5"); ticks(1, 1, "R4");
    // illegal period code keeps P=8
    wr(4'd10, 3'd0, 1, "R6"); trig(0, "R6"); ticks(7, 0, "R6"); ticks(1, 1, "R6");
    wr(4'd15, 3'd1, 1, "R6");
    // illegal style code
    wr(4'd1, 3'd6, 1, "R7"); wr(4'd1, 3'd7, 1, "R7");
    // x8 time-out: P=32
    wr(4'd0, 3'd2, 0, "R7"); trig(0, "R7"); ticks(31, 0, "R7"); ticks(1, 1, "R7");
    // x16 windowed: P=64, window opens at 32
    wr(4'd0, 3'd5, 0, "R7"); trig(0, "R7"); ticks(31, 0, "R7"); trig(1, "R7");
    // R11: legal write restarts running period (windowed P=8)
    wr(4'd1, 3'd1, 0, "R11"); trig(0, "R11"); ticks(6, 0, "R11");
    wr(4'd1, 3'd1, 0, "R11"); ticks(4, 0, "R11"); trig(0, "R11");
    // startup_i returns to start-up timing
    ticks(2, 0, "R8"); step(0,0,0,0,0,1,0,0,"R8"); ticks(10, 0, "R8"); trig(0, "R8");
    ticks(3, 0, "R3"); trig(1, "R3");
    // set wins over clear
    step(0,0,0,0,0,0,1,0,"R10");
    step(0,0,1,4'd12,3'd1,0,1,1,"R10");
    step(0,0,0,0,0,0,0,0,"R10");
    step(0,0,0,0,0,0,0,0,"R9");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    wait (done || cycles >= WD_LIMIT);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: timeout after %0d cycles, expected completion", cycles);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule